// File: doc/BRIEF.md
# Duplicated Load Value Queue

This block serves loads that a fault-tolerant instruction stream issues twice. Every load is presented once as an original copy and once as a duplicate copy, and a one-bit version tag tells them apart. Only the original copy reaches memory. The block records the original's address in a queue entry and forwards the read to memory. When the data returns, the block hands it to the original copy and stores it in the same entry, where a per-entry validated flag is then set.

The duplicate copy never touches memory. It is paired with the oldest entry that has not yet been consumed. Its address is compared with the recorded one, and on a match it receives the stored value in the same cycle and the entry is released. Memory traffic is therefore one access per program load, while address generation is still cross-checked across the two copies. A mismatch, or a duplicate with no original to pair with, sets a sticky fault flag. Memory must return read data in request order.

Top module: `dup_load_queue`

## Requirements
- R1: After reset the fault output is 0, no memory read, original response or duplicate response is valid, and the queue is empty, so a duplicate request sees req_ready high.
- R2: An original request (req_ver = 0) with a free entry drives mem_rd_valid high and mem_rd_addr equal to req_addr in the same cycle. It is accepted (req_ready high) exactly when mem_rd_ready is also high.
- R3: Every memory response (mem_rsp_valid) is passed to the original copy in the same cycle with unchanged data. It is also stored in the oldest entry still waiting for data.
- R4: A duplicate request (req_ver = 1) never raises mem_rd_valid.
- R5: Duplicates pair with entries in FIFO order. An accepted duplicate whose address equals the oldest unconsumed entry's address gets dup_rsp_valid high in the same cycle, with that entry's stored data, and the entry is freed.
- R6: A duplicate whose oldest unconsumed entry has no data yet sees req_ready low until the cycle after the data arrives.
- R7: While DEPTH entries are held, an original request sees req_ready low and mem_rd_valid low.
- R8: An accepted duplicate whose address differs from its entry's address gets no response, frees the entry, and drives fault high from the next cycle.
- R9: A duplicate presented while the queue holds no entry is accepted, gets no response, and drives fault high from the next cycle.
- R10: Once high, fault stays high until reset.
- R11: Entries are reused in circular order, so more than DEPTH loads in sequence are served correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ver | input | 1 | Copy tag: 0 original, 1 duplicate |
| req_addr | input | AW | Load address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_addr | output | AW | Read address to memory |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data returning, in request order |
| mem_rsp_data | input | DW | Returned read data |
| orig_rsp_valid | output | 1 | Response to the original copy |
| orig_rsp_data | output | DW | Data for the original copy |
| dup_rsp_valid | output | 1 | Response to the duplicate copy |
| dup_rsp_data | output | DW | Data bypassed to the duplicate copy |
| fault | output | 1 | Sticky detected-error flag |

## Verification
The bench fills the queue to DEPTH with responses held back and checks that the next original stalls; a design that miscounts occupancy would overwrite a live entry or refuse space it has. It presents a duplicate before its data has returned and while the data lands. A design that bypasses too early would hand back stale contents, and one that ignores the validated flag would do so silently. It runs more than DEPTH loads back to back so the pointers wrap, which exposes off-by-one wrap logic through wrong data. Finally it injects an address mismatch and an unpaired duplicate, where a broken design would answer the duplicate, miss the fault, or let it drop again.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
    typedef enum logic {
        VER_ORIG = 1'b0,
        VER_DUP  = 1'b1
    } ver_e;
endpackage

// File: rtl/dlq_ptr.sv
module dlq_ptr #(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    logic [PW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_ptr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PW'(DEPTH - 1));
endmodule

// File: rtl/dlq_store.sv
module dlq_store #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [PW-1:0] alloc_idx,
    input  logic [AW-1:0] alloc_addr,
    input  logic          fill_en,
    input  logic [PW-1:0] fill_idx,
    input  logic [DW-1:0] fill_data,
    input  logic          free_en,
    input  logic [PW-1:0] head_idx,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          head_filled
);
    typedef struct packed {
        logic          filled;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ent_t;

    ent_t ent_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_t e_d, e_q;

        always_comb begin
            e_d = e_q;
            if (free_en && head_idx == PW'(g)) begin
                e_d.filled = 1'b0;
            end
            if (alloc_en && alloc_idx == PW'(g)) begin
                e_d.filled = 1'b0;
                e_d.addr   = alloc_addr;
            end
            if (fill_en && fill_idx == PW'(g)) begin
                e_d.filled = 1'b1;
                e_d.data   = fill_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) e_q <= '0;
            else        e_q <= e_d;
        end

        assign ent_view[g] = e_q;
    end

    assign head_addr   = ent_view[head_idx].addr;
    assign head_data   = ent_view[head_idx].data;
    assign head_filled = ent_view[head_idx].filled;

    // R3: data lands only in an entry still waiting for it
    p_fill_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !ent_view[fill_idx].filled);
    // R11: a reused slot was released before reallocation
    p_alloc_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !ent_view[alloc_idx].filled);
endmodule

// File: rtl/dup_load_queue.sv
module dup_load_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_ver,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          orig_rsp_valid,
    output logic [DW-1:0] orig_rsp_data,
    output logic          dup_rsp_valid,
    output logic [DW-1:0] dup_rsp_data,
    output logic          fault
);
    import dlq_pkg::*;

    typedef struct packed {
        logic [CW-1:0] held;
        logic [CW-1:0] waiting;
        logic          fault;
    } state_t;

    state_t st_d, st_q;

    logic [PW-1:0] wr_idx, fill_idx, rd_idx;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          head_filled;

    logic is_dup, full, empty, dup_ok;
    logic orig_go, dup_go, dup_hit, consume, fill_go;

    always_comb begin
        is_dup  = (ver_e'(req_ver) == VER_DUP);
        full    = (st_q.held == CW'(DEPTH));
        empty   = (st_q.held == '0);
        dup_ok  = empty || head_filled;
        orig_go = req_valid && !is_dup && !full && mem_rd_ready;
        dup_go  = req_valid && is_dup && dup_ok;
        consume = dup_go && !empty;
        dup_hit = consume && (head_addr == req_addr);
        fill_go = mem_rsp_valid && (st_q.waiting != '0);

        st_d         = st_q;
        st_d.held    = st_q.held + CW'(orig_go) - CW'(consume);
        st_d.waiting = st_q.waiting + CW'(orig_go) - CW'(fill_go);
        st_d.fault   = st_q.fault || (dup_go && !dup_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dlq_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .adv(orig_go), .ptr(wr_idx));
    dlq_ptr #(.DEPTH(DEPTH)) u_fill_ptr (
        .clk(clk), .rst_n(rst_n), .adv(fill_go), .ptr(fill_idx));
    dlq_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .adv(consume), .ptr(rd_idx));

    dlq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (orig_go),
        .alloc_idx   (wr_idx),
        .alloc_addr  (req_addr),
        .fill_en     (fill_go),
        .fill_idx    (fill_idx),
        .fill_data   (mem_rsp_data),
        .free_en     (consume),
        .head_idx    (rd_idx),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .head_filled (head_filled)
    );

    assign req_ready      = is_dup ? dup_ok : (!full && mem_rd_ready);
    assign mem_rd_valid   = req_valid && !is_dup && !full;
    assign mem_rd_addr    = req_addr;
    assign orig_rsp_valid = mem_rsp_valid;
    assign orig_rsp_data  = mem_rsp_data;
    assign dup_rsp_valid  = dup_hit;
    assign dup_rsp_data   = head_data;
    assign fault          = st_q.fault;

    p_dup_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ver) |-> !mem_rd_valid);
    p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held == CW'(DEPTH) && req_valid && !req_ver) |-> !req_ready);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.held <= CW'(DEPTH)) && (st_q.waiting <= st_q.held));
    p_wait_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ver && !empty && !head_filled) |-> !req_ready);
    p_mismatch_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && head_addr != req_addr) |=> fault);
    p_orphan_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ver && empty) |=> fault);
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

// File: tb/dup_load_queue_tb_top.sv
`timescale 1ns/1ps
module dup_load_queue_tb_top;
    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_ver = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          mem_rd_valid;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          orig_rsp_valid, dup_rsp_valid, fault;
    logic [DW-1:0] orig_rsp_data, dup_rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] addr_q[$];
    logic [DW-1:0] data_q[$];
    logic [AW-1:0] memq[$];
    bit            fault_m = 0;

    always #4 clk = ~clk;

    dup_load_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ver(req_ver), .req_addr(req_addr),
        .req_ready(req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .orig_rsp_valid(orig_rsp_valid), .orig_rsp_data(orig_rsp_data),
        .dup_rsp_valid(dup_rsp_valid), .dup_rsp_data(dup_rsp_data),
        .fault(fault)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 0; req_ver = 0; req_addr = '0;
        mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        addr_q.delete(); data_q.delete(); memq.delete(); fault_m = 0;
        rst_n = 1'b1;
    endtask

    // One clock: drive, compare against the model, then advance the model.
    task automatic step(input logic v, input logic ver, input logic [AW-1:0] a,
                        input logic rdy, input logic rsp_en);
        int n;
        bit full, empty, hf, exp_ready, exp_mv, exp_dv, acc_o, acc_d, rsp;
        logic [DW-1:0] rdata;
        @(negedge clk);
        rsp = rsp_en && (memq.size() > 0);
        rdata = rsp ? mem_word(memq[0]) : '0;
        req_valid = v; req_ver = ver; req_addr = a;
        mem_rd_ready = rdy; mem_rsp_valid = rsp; mem_rsp_data = rdata;
        #2;
        n = addr_q.size();
        full = (n == DEPTH);
        empty = (n == 0);
        hf = (data_q.size() > 0);
        exp_ready = ver ? (empty || hf) : (!full && rdy);
        exp_mv = v && !ver && !full;
        exp_dv = v && ver && hf && (addr_q[0] == a);
        chk("R6/R7 req_ready", 32'(req_ready), 32'(exp_ready));
        chk("R2/R4/R7 mem_rd_valid", 32'(mem_rd_valid), 32'(exp_mv));
        if (exp_mv) chk("R2 mem_rd_addr", mem_rd_addr, a);
        chk("R3 orig_rsp_valid", 32'(orig_rsp_valid), 32'(rsp));
        if (rsp) chk("R3 orig_rsp_data", orig_rsp_data, rdata);
        chk("R5/R8 dup_rsp_valid", 32'(dup_rsp_valid), 32'(exp_dv));
        if (exp_dv) chk("R5 dup_rsp_data", dup_rsp_data, data_q[0]);
        chk("R8/R9/R10 fault", 32'(fault), 32'(fault_m));
        @(posedge clk);
        acc_o = v && !ver && !full && rdy;
        acc_d = v && ver && (empty || hf);
        if (acc_d) begin
            if (empty) fault_m = 1;
            else begin
                if (addr_q[0] != a) fault_m = 1;
                void'(addr_q.pop_front());
                void'(data_q.pop_front());
            end
        end
        if (rsp) begin
            data_q.push_back(rdata);
            void'(memq.pop_front());
        end
        if (acc_o) begin
            addr_q.push_back(a);
            memq.push_back(a);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, '0, 0, 0);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        req_ver = 1; #2;
        chk("R1 fault", 32'(fault), 0);
        chk("R1 mem_rd_valid", 32'(mem_rd_valid), 0);
        chk("R1 dup_rsp_valid", 32'(dup_rsp_valid), 0);
        chk("R1 orig_rsp_valid", 32'(orig_rsp_valid), 0);
        chk("R1 req_ready empty", 32'(req_ready), 1);

        // R2 R3 R5: single load pair
        step(1, 0, 32'h100, 1, 0);
        step(0, 0, '0, 0, 1);
        step(1, 1, 32'h100, 0, 0);

        // R7 R11: fill to DEPTH, extra original stalls, drain in order
        for (int i = 0; i < DEPTH; i++) step(1, 0, 32'h200 + 32'(i * 4), 1, 0);
        step(1, 0, 32'h300, 1, 0);
        chk("R7 held count", 32'(addr_q.size()), DEPTH);
        for (int i = 0; i < DEPTH; i++) step(0, 0, '0, 0, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 1, 32'h200 + 32'(i * 4), 0, 0);

        // R6: duplicate waits for data, then is served
        step(1, 0, 32'h400, 1, 0);
        step(1, 1, 32'h400, 0, 0);
        step(1, 1, 32'h400, 0, 1);
        step(1, 1, 32'h400, 0, 0);

        // R5 R11: random interleaving with correct duplicates, wraps often
        for (int c = 0; c < 600; c++) begin
            bit pick_dup;
            pick_dup = ($urandom_range(1) == 1) && (addr_q.size() > 0);
            if (pick_dup)
                step(1, 1, addr_q[0], 1'($urandom_range(1)), 1'($urandom_range(1)));
            else
                step(1'($urandom_range(1)), 0, $urandom, 1'($urandom_range(1)),
                     1'($urandom_range(1)));
        end
        chk("R8 no spurious fault", 32'(fault), 0);

        // R8 R10: address mismatch
        do_reset();
        step(1, 0, 32'h500, 1, 0);
        step(0, 0, '0, 0, 1);
        step(1, 1, 32'h504, 0, 0);
        idle(3);
        chk("R10 fault held", 32'(fault), 1);
        chk("R8 entry freed", 32'(addr_q.size()), 0);

        // R9 R10: duplicate with nothing to pair
        do_reset();
        step(1, 1, 32'h600, 0, 0);
        idle(4);
        chk("R9 orphan fault", 32'(fault), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule